// File: doc/BRIEF.md
# MAC Interrupt Status and Moderation

This block gathers single-cycle event pulses from the rest of an Ethernet MAC into a 16-bit pending-event register and drives one level-sensitive interrupt line. The line is high whenever any pending event is also enabled in a 16-bit mask register. Software reads the pending register to learn which events occurred, and that read empties it. An event that arrives in the same cycle as the read is not lost.

Receive-complete and transmit-complete events do not reach the pending register directly. Each passes through its own moderation stage, set by a register that holds a packet-count threshold in bits [15:8] and a waiting time in bits [7:0]. The waiting time is counted in ticks of `TICK_CYCLES` clocks. A moderated bit is raised when the count of held completions reaches the threshold, or when the waiting time runs out after the first held completion, whichever comes first. A moderation value of zero passes every completion straight through.

Software reaches the registers through a simple port: a one-cycle write strobe, a one-cycle read strobe, a 2-bit address and 16-bit write data. Read data is registered.

Top module: `irqm_ctrl`

## Requirements
- R1: Event pulses set pending bits with this mapping: bit 0 receive done, bit 1 receive descriptor starvation, bit 2 receive FIFO full, bit 3 receive early, bit 4 transmit done, bit 7 transmit early, bit 8 event-counter overflow, bit 9 link change. The other bits latch their inputs the same way. A pending bit is set whether or not it is enabled, and it stays set until the pending register is read.
- R2: Register addresses are 0 pending, 1 enable mask, 2 transmit moderation, 3 receive moderation. A read strobe puts the selected value on `reg_rdata` after the next rising edge, and `reg_rdata` holds it until the next read.
- R3: Reading address 0 returns the pending bits and clears them at the same edge.
- R4: An event pulse in the same cycle as a pending-register read stays pending after the read.
- R5: `irq_o` is high exactly when some bit is set in both the pending register and the enable mask. It follows register state with no added cycle.
- R6: Writing 0 to the enable mask drops `irq_o` while the events stay pending. Writing the old mask back raises `irq_o` again.
- R7: With a moderation value of 0, a completion pulse sets its pending bit (bit 0 for receive, bit 4 for transmit) at the same edge that samples it.
- R8: With a nonzero threshold C in bits [15:8], the C-th held completion sets the pending bit at the edge that samples it, and earlier completions do not set it.
- R9: With a nonzero waiting time T in bits [7:0], if the count threshold has not fired, the pending bit is set T*TICK_CYCLES+1 edges after the edge that sampled the first held completion, and not before.
- R10: Writes to address 0 have no effect on the pending register. The enable and moderation registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_i | input | 16 | Event pulses, one bit per event |
| irq_o | output | 1 | Level interrupt request |

## Verification
Direct events and unmoderated completions show up in the pending register after the edge that samples the pulse, and `irq_o` changes in that same cycle. Read data and the clear both take effect at the edge that samples the read strobe. The timer-moderated bit is due exactly T*TICK_CYCLES+1 edges after its first completion was sampled. The bench drives and samples on falling edges, counts each edge to its expected result, and checks both the cycle just before a result is due and the cycle it is due. This catches results that arrive one cycle early or one cycle late.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int DW = 16;

    // pending bit positions
    localparam int EV_RX_DONE   = 0;
    localparam int EV_RX_NODESC = 1;
    localparam int EV_RX_FULL   = 2;
    localparam int EV_RX_EARLY  = 3;
    localparam int EV_TX_DONE   = 4;
    localparam int EV_TX_EARLY  = 7;
    localparam int EV_CNT_OVF   = 8;
    localparam int EV_LINK_CHG  = 9;

    localparam int NUM_MOD = 2;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TXMOD = 2'd2,
        SEL_RXMOD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] pkt_thr;
        logic [7:0] wait_ticks;
    } mod_cfg_t;

    // moderator 0 serves transmit, moderator 1 serves receive
    function automatic int mod_bit(input int idx);
        return (idx == 0) ? EV_TX_DONE : EV_RX_DONE;
    endfunction

    function automatic logic [DW-1:0] mod_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_MOD; i++) m[mod_bit(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqm_moderator.sv
module irqm_moderator #(
    parameter int TICK_CYCLES = 4,
    parameter int CNT_W       = 8,
    parameter int TIM_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic [TIM_W-1:0] cfg_tim,
    input  logic             done_i,
    output logic             fire_o
);
    localparam int ELAP_W = TIM_W + $clog2(TICK_CYCLES) + 1;

    logic [CNT_W-1:0]  pend_q;
    logic [ELAP_W-1:0] elap_q;
    logic [ELAP_W-1:0] limit;
    logic [CNT_W:0]    cnt_inc;
    logic              bypass, by_count, by_timer;

    always_comb begin
        bypass   = (cfg_cnt == '0) && (cfg_tim == '0);
        cnt_inc  = {1'b0, pend_q} + {{CNT_W{1'b0}}, 1'b1};
        limit    = ELAP_W'(cfg_tim) * ELAP_W'(TICK_CYCLES);
        by_count = done_i && (cfg_cnt != '0) && (cnt_inc >= {1'b0, cfg_cnt});
        by_timer = (pend_q != '0) && (cfg_tim != '0) && (elap_q >= limit);
        fire_o   = bypass ? done_i : (by_count || by_timer);
    end

    always_ff @(posedge clk) begin
        if (rst || fire_o || bypass) begin
            pend_q <= '0;
            elap_q <= '0;
        end else begin
            if (done_i && (pend_q != '1))
                pend_q <= pend_q + 1'b1;
            if ((pend_q != '0) && (elap_q != '1))
                elap_q <= elap_q + 1'b1;
        end
    end

    // R8 R9
    fire_src_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> (done_i || (pend_q != '0)));

    // R8
    hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !fire_o && !bypass) |=> (pend_q != '0));

    // R9
    timer_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |=> (elap_q == '0));

endmodule

// File: rtl/irqm_status.sv
module irqm_status
    import irqm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_i,
    input  logic          clr_i,
    output logic [DW-1:0] stat_q
);
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= (clr_i ? '0 : stat_q) | set_i;
    end

    // R1
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R4
    no_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (set_i == '0)) |=> (stat_q == '0));

endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
    import irqm_pkg::*;
#(
    parameter int TICK_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic [15:0]   evt_i,
    output logic          irq_o
);
    localparam logic [DW-1:0] MODM = mod_mask();

    reg_sel_e              sel;
    logic     [DW-1:0]     mask_q;
    mod_cfg_t              cfg_q [NUM_MOD];
    logic     [NUM_MOD-1:0] fire;
    logic     [DW-1:0]     set_vec;
    logic     [DW-1:0]     stat_q;
    logic                  clr;

    assign sel = reg_sel_e'(reg_addr);
    assign clr = reg_rd && (sel == SEL_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            for (int i = 0; i < NUM_MOD; i++) cfg_q[i] <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_MASK:  mask_q   <= reg_wdata;
                SEL_TXMOD: cfg_q[0] <= mod_cfg_t'(reg_wdata);
                SEL_RXMOD: cfg_q[1] <= mod_cfg_t'(reg_wdata);
                default:   ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
            irqm_moderator #(
                .TICK_CYCLES(TICK_CYCLES),
                .CNT_W(8),
                .TIM_W(8)
            ) u_mod (
                .clk    (clk),
                .rst    (rst),
                .cfg_cnt(cfg_q[g].pkt_thr),
                .cfg_tim(cfg_q[g].wait_ticks),
                .done_i (evt_i[mod_bit(g)]),
                .fire_o (fire[g])
            );
        end
    endgenerate

    always_comb begin
        set_vec = evt_i & ~MODM;
        for (int i = 0; i < NUM_MOD; i++) set_vec[mod_bit(i)] = fire[i];
    end

    irqm_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr),
        .stat_q(stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd) begin
            case (sel)
                SEL_PEND:  reg_rdata <= stat_q;
                SEL_MASK:  reg_rdata <= mask_q;
                SEL_TXMOD: reg_rdata <= cfg_q[0];
                default:   reg_rdata <= cfg_q[1];
            endcase
        end
    end

    assign irq_o = |(stat_q & mask_q);

    // R2
    rd_pend_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (reg_rdata == $past(stat_q)));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_o);

    // R10
    pend_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (sel == SEL_PEND) && !reg_rd && (set_vec == '0))
        |=> (stat_q == $past(stat_q)));

    // R7
    direct_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & ~MODM) != '0) |=> ((stat_q & $past(evt_i & ~MODM)) == $past(evt_i & ~MODM)));

endmodule

// File: tb/sim_irqm_ctrl.sv
`timescale 1ns/1ps
module sim_irqm_ctrl;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata, evt_i;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    irqm_ctrl #(.TICK_CYCLES(TICK)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); evt_i = m;
        @(negedge clk); evt_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R5 irq after reset", {15'd0, irq_o}, 16'd0);
        rd(2'd0, d); chk("R2 pending after reset", d, 16'h0000);
        rd(2'd1, d); chk("R2 mask after reset", d, 16'h0000);
        rd(2'd2, d); chk("R2 txmod after reset", d, 16'h0000);
    endtask

    task automatic t_latch_clear();
        logic [15:0] d;
        pulse(16'h0004);
        chk("R1 masked event no irq", {15'd0, irq_o}, 16'd0);
        pulse(16'h0300);
        rd(2'd0, d); chk("R1 R3 pending read", d, 16'h0304);
        rd(2'd0, d); chk("R3 cleared after read", d, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        wr(2'd1, 16'h0084);
        pulse(16'h0080);
        chk("R5 enabled event raises irq", {15'd0, irq_o}, 16'd1);
        wr(2'd1, 16'h0000);
        chk("R6 zero mask drops irq", {15'd0, irq_o}, 16'd0);
        wr(2'd1, 16'h0084);
        chk("R6 restored mask raises irq", {15'd0, irq_o}, 16'd1);
        rd(2'd1, d); chk("R10 mask readback", d, 16'h0084);
        rd(2'd0, d); chk("R3 pending value", d, 16'h0080);
        chk("R5 irq low after clear", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_read_collide();
        logic [15:0] d;
        pulse(16'h0002);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd0; evt_i = 16'h0200;
        @(negedge clk); reg_rd = 1'b0; evt_i = '0;
        chk("R4 read data in collision", reg_rdata, 16'h0002);
        rd(2'd0, d); chk("R4 colliding event kept", d, 16'h0200);
    endtask

    task automatic t_wr_pending();
        logic [15:0] d;
        pulse(16'h0008);
        wr(2'd0, 16'hFFFF);
        wr(2'd0, 16'h0000);
        rd(2'd0, d); chk("R10 pending write ignored", d, 16'h0008);
    endtask

    task automatic t_immediate();
        logic [15:0] d;
        wr(2'd1, 16'h0011);
        pulse(16'h0001);
        chk("R7 rx done immediate", {15'd0, irq_o}, 16'd1);
        rd(2'd0, d); chk("R7 rx bit value", d, 16'h0001);
        pulse(16'h0010);
        chk("R7 tx done immediate", {15'd0, irq_o}, 16'd1);
        rd(2'd0, d); chk("R7 tx bit value", d, 16'h0010);
    endtask

    task automatic t_count();
        logic [15:0] d;
        wr(2'd3, 16'h0300);
        rd(2'd3, d); chk("R10 rxmod readback", d, 16'h0300);
        pulse(16'h0001); pulse(16'h0001);
        chk("R8 below threshold", {15'd0, irq_o}, 16'd0);
        pulse(16'h0001);
        chk("R8 threshold reached", {15'd0, irq_o}, 16'd1);
        rd(2'd0, d); chk("R8 rx bit", d, 16'h0001);
        pulse(16'h0001);
        chk("R8 count restarts", {15'd0, irq_o}, 16'd0);
        wr(2'd3, 16'h0000);
        pulse(16'h0001);
        rd(2'd0, d);
    endtask

    task automatic t_timer(input logic [7:0] thr, input int t, input string req);
        logic [15:0] d;
        wr(2'd2, {thr, 8'(t)});
        pulse(16'h0010);
        idle(t * TICK - 1);
        chk(req, {15'd0, irq_o}, 16'd0);
        @(negedge clk);
        chk(req, {15'd0, irq_o}, 16'd0);
        @(negedge clk);
        chk(req, {15'd0, irq_o}, 16'd1);
        rd(2'd0, d); chk(req, d, 16'h0010);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; evt_i = 0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_latch_clear();
        t_mask();
        t_read_collide();
        t_wr_pending();
        t_immediate();
        t_count();
        t_timer(8'd0, 2, "R9 tx timer only");
        t_timer(8'd3, 3, "R9 timer before count");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule